// File: doc/BRIEF.md
# Floating-Point Constant Push Unit

This block carries out the seven constant-load operations of a floating-point register stack with eight registers. A start strobe comes with the selector byte, which is the byte that follows the D9 escape. The constant is held inside the block with two extra significand bits. The block rounds it to the 80-bit double extended-precision format under the 2-bit rounding-control field that is active at the time. It then moves the TOP pointer down by one and stores the result in the register that has become ST(0). Every accepted operation completes in one clock.

The register file keeps an 80-bit word and a 2-bit tag for each of its eight physical slots. A push whose target slot is still in use is a stack overflow. In that case the block stores the quiet-NaN indefinite value in place of the constant, sets C1, and sets a stack-fault flag that stays set. Rounding never sets C1 and never signals an inexact result. Words leave the block through a registered read port addressed relative to TOP, so ST(i) is read by giving i.

Top module: `fpu_const_push`

## Requirements
- R1: With rounding mode 00, selector E8 pushes +1.0 (3FFF_8000000000000000). E9 pushes log2(10) (4000_D49A784BCD1B8AFE). EA pushes log2(e) (3FFF_B8AA3B295C17F0BC). EB pushes pi (4000_C90FDAA22168C235). EC pushes log10(2) (3FFD_9A209A84FBCFF799). ED pushes ln(2) (3FFE_B17217F7D1CF79AC). EE pushes +0.0 (all zero). Each value is written as {sign, 15-bit biased exponent, 64-bit significand}.
- R2: The rounding mode is decoded as 00 nearest, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Modes 01 and 11 truncate the two extra bits. Mode 10 adds one unit whenever either extra bit is set. Mode 00 adds one unit when the upper extra bit is set. For example, pi loads as ...C234 under 01 and 11 and as ...C235 under 00 and 10.
- R3: Rounding leaves C1 at 0 even when the result was rounded up. The block has no inexact indication.
- R4: An accepted push sets TOP to (TOP-1) mod 8 and writes the new ST(0). The read port returns ST(rd_slot), which is physical slot (TOP+rd_slot) mod 8. Its value and tag appear one clock after the address and TOP settle.
- R5: Reset sets TOP to 0, marks all eight tags empty and clears C1, the stack fault and done. The tag code is 00 valid, 01 zero, 10 special and 11 empty. +0.0 is tagged 01, and the other constants are tagged 00.
- R6: If the slot at TOP-1 is not empty, the push still decrements TOP. It stores FFFF_C000000000000000 tagged 10, sets C1 to 1 and sets the stack fault.
- R7: The stack fault stays set until reset. C1 is written on every accepted push: 1 on overflow, 0 otherwise.
- R8: A start with a selector outside E8 to EE is ignored. TOP, the tags and the flags do not change, and done stays low.
- R9: `done` is high for exactly the one clock that follows each accepted push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the selected constant push |
| op_code | input | 8 | Selector byte following D9 (E8 to EE) |
| rnd_mode | input | 2 | Rounding-control field |
| rd_slot | input | 3 | Stack-relative index i of ST(i) to read |
| done | output | 1 | Push completed in the previous clock |
| top_ptr | output | 3 | Current TOP pointer |
| cc_c1 | output | 1 | Condition code C1 (overflow of the last push) |
| stack_fault | output | 1 | Sticky stack-overflow fault flag |
| rd_value | output | 80 | Extended-precision word of ST(rd_slot) |
| rd_tag | output | 2 | Tag of ST(rd_slot) |

## Verification
The assertions check on every clock that an accepted push moves TOP down by exactly one and that an unknown selector leaves TOP and done untouched. They also check that done follows only accepted pushes, that the fault flag never clears outside reset, and that C1 is never set without the fault. Only the bench scenarios can show the rounded bit patterns under each rounding mode for each constant, the quiet-NaN substitution and its tag on overflow, and the stack ordering seen through the relative read port.

// File: rtl/fpu_cl_pkg.sv
package fpu_cl_pkg;
  localparam int SIG_W    = 64;
  localparam int GRD_W    = 2;
  localparam int EXP_W    = 15;
  localparam int WORD_W   = 1 + EXP_W + SIG_W;
  localparam int EXT_W    = SIG_W + GRD_W;
  localparam int EXP_BIAS = 16383;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_TRNC = 2'b11
  } rnd_e;

  // quiet NaN indefinite: sign set, exponent all ones, top two significand bits set
  localparam logic [WORD_W-1:0] QNAN_IND =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};
endpackage

// File: rtl/fpu_cl_const_rom.sv
module fpu_cl_const_rom
  import fpu_cl_pkg::*;
(
  input  logic [7:0]       sel,
  output logic             hit,
  output logic             is_zero,
  output logic [EXT_W-1:0] sig_ext,
  output logic [EXP_W-1:0] exp_b
);
  // significands truncated from the exact values, two extra bits kept
  always_comb begin
    hit     = 1'b1;
    is_zero = 1'b0;
    sig_ext = '0;
    exp_b   = '0;
    unique case (sel)
      8'hE8: begin sig_ext = {64'h8000000000000000, 2'b00}; exp_b = EXP_W'(EXP_BIAS);     end
      8'hE9: begin sig_ext = {64'hD49A784BCD1B8AFE, 2'b01}; exp_b = EXP_W'(EXP_BIAS + 1); end
      8'hEA: begin sig_ext = {64'hB8AA3B295C17F0BB, 2'b10}; exp_b = EXP_W'(EXP_BIAS);     end
      8'hEB: begin sig_ext = {64'hC90FDAA22168C234, 2'b11}; exp_b = EXP_W'(EXP_BIAS + 1); end
      8'hEC: begin sig_ext = {64'h9A209A84FBCFF798, 2'b10}; exp_b = EXP_W'(EXP_BIAS - 2); end
      8'hED: begin sig_ext = {64'hB17217F7D1CF79AB, 2'b11}; exp_b = EXP_W'(EXP_BIAS - 1); end
      8'hEE: begin is_zero = 1'b1; end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpu_cl_round.sv
module fpu_cl_round
  import fpu_cl_pkg::*;
(
  input  logic [EXT_W-1:0]  sig_ext,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [1:0]        mode,
  output logic [WORD_W-1:0] word
);
  logic [GRD_W-1:0] grd;
  logic             bump;
  logic [SIG_W:0]   sum;
  logic [SIG_W-1:0] sig_r;
  logic [EXP_W-1:0] exp_r;

  assign grd = sig_ext[GRD_W-1:0];

  // every stored constant is either exact (extra bits zero) or irrational,
  // so the discarded tail is nonzero and the top extra bit alone decides nearest
  always_comb begin
    unique case (rnd_e'(mode))
      RND_NEAR: bump = grd[GRD_W-1];
      RND_UP:   bump = |grd;
      default:  bump = 1'b0;
    endcase
  end

  assign sum = {1'b0, sig_ext[EXT_W-1:GRD_W]} + (SIG_W+1)'(bump);

  always_comb begin
    if (sum[SIG_W]) begin
      sig_r = {1'b1, {(SIG_W-1){1'b0}}};
      exp_r = exp_in + EXP_W'(1);
    end else begin
      sig_r = sum[SIG_W-1:0];
      exp_r = exp_in;
    end
  end

  assign word = {1'b0, exp_r, sig_r};
endmodule

// File: rtl/fpu_cl_regfile.sv
module fpu_cl_regfile
  import fpu_cl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        wtag,
  input  logic [AW-1:0]     paddr,
  output logic [1:0]        ptag,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        rtag
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [1:0]        tag_q [DEPTH];

  // data array: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

  // tags live in flops so the overflow probe can be combinational
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= TAG_EMPTY;
    end else if (we) begin
      tag_q[waddr] <= wtag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rtag <= TAG_EMPTY;
    else     rtag <= tag_q[raddr];
  end

  assign ptag = tag_q[paddr];
endmodule

// File: rtl/fpu_const_push.sv
module fpu_const_push
  import fpu_cl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        op_code,
  input  logic [1:0]        rnd_mode,
  input  logic [AW-1:0]     rd_slot,
  output logic              done,
  output logic [AW-1:0]     top_ptr,
  output logic              cc_c1,
  output logic              stack_fault,
  output logic [WORD_W-1:0] rd_value,
  output logic [1:0]        rd_tag
);
  logic             hit, is_zero;
  logic [EXT_W-1:0] sig_ext;
  logic [EXP_W-1:0] exp_b;
  logic [WORD_W-1:0] rounded, wr_word;
  logic [AW-1:0]    top_q, new_top, rd_addr;
  logic [1:0]       probe_tag, wr_tag;
  logic             accept, full;
  logic             c1_q, fault_q, done_q;

  fpu_cl_const_rom u_rom (
    .sel     (op_code),
    .hit     (hit),
    .is_zero (is_zero),
    .sig_ext (sig_ext),
    .exp_b   (exp_b)
  );

  fpu_cl_round u_rnd (
    .sig_ext (sig_ext),
    .exp_in  (exp_b),
    .mode    (rnd_mode),
    .word    (rounded)
  );

  assign accept  = start && hit;
  assign new_top = top_q - AW'(1);
  assign full    = (probe_tag != TAG_EMPTY);
  assign rd_addr = top_q + rd_slot;

  always_comb begin
    if (full) begin
      wr_word = QNAN_IND;
      wr_tag  = TAG_SPECIAL;
    end else if (is_zero) begin
      wr_word = '0;
      wr_tag  = TAG_ZERO;
    end else begin
      wr_word = rounded;
      wr_tag  = TAG_VALID;
    end
  end

  fpu_cl_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (accept),
    .waddr (new_top),
    .wdata (wr_word),
    .wtag  (wr_tag),
    .paddr (new_top),
    .ptag  (probe_tag),
    .raddr (rd_addr),
    .rdata (rd_value),
    .rtag  (rd_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q   <= '0;
      c1_q    <= 1'b0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept;
      if (accept) begin
        top_q   <= new_top;
        c1_q    <= full;
        fault_q <= fault_q | full;
      end
    end
  end

  assign top_ptr     = top_q;
  assign cc_c1       = c1_q;
  assign stack_fault = fault_q;
  assign done        = done_q;
endmodule

// File: rtl/fpu_const_push_chk.sv
module fpu_const_push_chk #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [7:0]    op_code,
  input logic [AW-1:0] top_ptr,
  input logic          done,
  input logic          cc_c1,
  input logic          stack_fault
);
  logic known_op;
  assign known_op = (op_code >= 8'hE8) && (op_code <= 8'hEE);

  // R4
  top_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (start && known_op) |=> (top_ptr == AW'($past(top_ptr) - AW'(1))));

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !known_op) |=> ($stable(top_ptr) && !done));

  // R9
  done_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (start && known_op) |=> done);

  // R9
  done_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !(start && known_op) |=> !done);

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stack_fault |=> stack_fault);

  // R6
  c1_fault_chk: assert property (@(posedge clk) disable iff (rst)
    cc_c1 |-> stack_fault);
endmodule

bind fpu_const_push fpu_const_push_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .op_code     (op_code),
  .top_ptr     (top_ptr),
  .done        (done),
  .cc_c1       (cc_c1),
  .stack_fault (stack_fault)
);

// File: tb/sim_fpu_const_push.sv
module sim_fpu_const_push;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [1:0]  rnd_mode = 2'b00;
  logic [2:0]  rd_slot = 3'd0;
  logic        done, cc_c1, stack_fault;
  logic [2:0]  top_ptr;
  logic [79:0] rd_value;
  logic [1:0]  rd_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fpu_const_push u0 (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .rnd_mode(rnd_mode),
    .rd_slot(rd_slot), .done(done), .top_ptr(top_ptr), .cc_c1(cc_c1),
    .stack_fault(stack_fault), .rd_value(rd_value), .rd_tag(rd_tag)
  );

  // {selector, mode, tag, expected word}
  localparam logic [91:0] VEC [28] = '{
    {8'hE8, 2'd0, 2'd0, 80'h3FFF_8000000000000000},
    {8'hE8, 2'd1, 2'd0, 80'h3FFF_8000000000000000},
    {8'hE8, 2'd2, 2'd0, 80'h3FFF_8000000000000000},
    {8'hE8, 2'd3, 2'd0, 80'h3FFF_8000000000000000},
    {8'hE9, 2'd0, 2'd0, 80'h4000_D49A784BCD1B8AFE},
    {8'hE9, 2'd1, 2'd0, 80'h4000_D49A784BCD1B8AFE},
    {8'hE9, 2'd2, 2'd0, 80'h4000_D49A784BCD1B8AFF},
    {8'hE9, 2'd3, 2'd0, 80'h4000_D49A784BCD1B8AFE},
    {8'hEA, 2'd0, 2'd0, 80'h3FFF_B8AA3B295C17F0BC},
    {8'hEA, 2'd1, 2'd0, 80'h3FFF_B8AA3B295C17F0BB},
    {8'hEA, 2'd2, 2'd0, 80'h3FFF_B8AA3B295C17F0BC},
    {8'hEA, 2'd3, 2'd0, 80'h3FFF_B8AA3B295C17F0BB},
    {8'hEB, 2'd0, 2'd0, 80'h4000_C90FDAA22168C235},
    {8'hEB, 2'd1, 2'd0, 80'h4000_C90FDAA22168C234},
    {8'hEB, 2'd2, 2'd0, 80'h4000_C90FDAA22168C235},
    {8'hEB, 2'd3, 2'd0, 80'h4000_C90FDAA22168C234},
    {8'hEC, 2'd0, 2'd0, 80'h3FFD_9A209A84FBCFF799},
    {8'hEC, 2'd1, 2'd0, 80'h3FFD_9A209A84FBCFF798},
    {8'hEC, 2'd2, 2'd0, 80'h3FFD_9A209A84FBCFF799},
    {8'hEC, 2'd3, 2'd0, 80'h3FFD_9A209A84FBCFF798},
    {8'hED, 2'd0, 2'd0, 80'h3FFE_B17217F7D1CF79AC},
    {8'hED, 2'd1, 2'd0, 80'h3FFE_B17217F7D1CF79AB},
    {8'hED, 2'd2, 2'd0, 80'h3FFE_B17217F7D1CF79AC},
    {8'hED, 2'd3, 2'd0, 80'h3FFE_B17217F7D1CF79AB},
    {8'hEE, 2'd0, 2'd1, 80'h0},
    {8'hEE, 2'd1, 2'd1, 80'h0},
    {8'hEE, 2'd2, 2'd1, 80'h0},
    {8'hEE, 2'd3, 2'd1, 80'h0}
  };

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drives one start pulse; returns at the falling edge after the capturing edge
  task automatic push(input logic [7:0] op, input logic [1:0] md);
    @(negedge clk);
    start = 1'b1; op_code = op; rnd_mode = md;
    @(negedge clk);
    start = 1'b0;
  endtask

  // registered read: value settles one clock after the address
  task automatic read_st(input logic [2:0] slot);
    rd_slot = slot;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R5 reset state
    do_reset();
    @(negedge clk);
    chk("R5 top", 80'(top_ptr), 80'd0);
    chk("R5 c1", 80'(cc_c1), 80'd0);
    chk("R5 fault", 80'(stack_fault), 80'd0);
    chk("R5 done", 80'(done), 80'd0);
    for (int s = 0; s < 8; s++) begin
      read_st(3'(s));
      chk("R5 tag empty", 80'(rd_tag), 80'd3);
    end

    // R1 R2 R3 R4 R9: every selector under every rounding mode
    for (int v = 0; v < 28; v++) begin
      do_reset();
      push(VEC[v][91:84], VEC[v][83:82]);
      chk("R9 done", 80'(done), 80'd1);
      chk("R4 top wrap", 80'(top_ptr), 80'd7);
      chk("R3 c1 after rounding", 80'(cc_c1), 80'd0);
      read_st(3'd0);
      chk("R1 R2 value", rd_value, VEC[v][79:0]);
      chk("R5 tag", 80'(rd_tag), 80'(VEC[v][81:80]));
      chk("R9 done drops", 80'(done), 80'd0);
    end

    // R8 unknown selectors are ignored
    do_reset();
    push(8'hE7, 2'd0);
    chk("R8 done E7", 80'(done), 80'd0);
    push(8'hEF, 2'd2);
    chk("R8 done EF", 80'(done), 80'd0);
    push(8'h00, 2'd0);
    chk("R8 top", 80'(top_ptr), 80'd0);
    read_st(3'd7);
    chk("R8 tag slot 7", 80'(rd_tag), 80'd3);
    chk("R8 c1", 80'(cc_c1), 80'd0);

    // R4 stack order through relative read port
    do_reset();
    push(8'hE8, 2'd0);
    push(8'hEB, 2'd0);
    chk("R4 top", 80'(top_ptr), 80'd6);
    read_st(3'd0);
    chk("R4 ST0", rd_value, 80'h4000_C90FDAA22168C235);
    read_st(3'd1);
    chk("R4 ST1", rd_value, 80'h3FFF_8000000000000000);
    read_st(3'd2);
    chk("R4 ST2 empty", 80'(rd_tag), 80'd3);

    // R6 R7 fill all eight, then overflow
    do_reset();
    for (int k = 0; k < 8; k++) begin
      push(8'hED, 2'd0);
      chk("R7 c1 no overflow", 80'(cc_c1), 80'd0);
    end
    chk("R6 top full", 80'(top_ptr), 80'd0);
    chk("R6 no fault yet", 80'(stack_fault), 80'd0);
    push(8'hE8, 2'd0);
    chk("R6 c1", 80'(cc_c1), 80'd1);
    chk("R6 fault", 80'(stack_fault), 80'd1);
    chk("R6 top", 80'(top_ptr), 80'd7);
    read_st(3'd0);
    chk("R6 nan", rd_value, 80'hFFFF_C000000000000000);
    chk("R6 tag special", 80'(rd_tag), 80'd2);
    read_st(3'd1);
    chk("R6 ST1 kept", rd_value, 80'h3FFE_B17217F7D1CF79AC);
    push(8'hE8, 2'd0);
    chk("R7 fault sticky", 80'(stack_fault), 80'd1);
    chk("R7 top", 80'(top_ptr), 80'd6);
    repeat (3) @(negedge clk);
    chk("R7 fault holds idle", 80'(stack_fault), 80'd1);
    do_reset();
    @(negedge clk);
    chk("R7 fault cleared", 80'(stack_fault), 80'd0);
    chk("R5 c1 cleared", 80'(cc_c1), 80'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule